// File: doc/BRIEF.md
# UART Receiver with Busy-Signalling RTS

This block takes a serial line carrying 8N1 characters and turns it into bytes. Each character has a low start bit, eight data bits sent least significant first, and a high stop bit. There is no parity bit. The line passes through two synchronising flops and is sampled at sixteen times the bit rate. A falling edge begins a frame only if the line is still low at the middle of the start bit. Each data bit is taken at its own midpoint.

A frame with a good stop bit does not enter the receive FIFO at once. It first spends a fixed number of clock cycles in a transfer step, and the byte is written at the end of that step. The RTS output signals that the block is busy: it is high for the whole transfer step and while the FIFO is full. Every accepted byte therefore produces a short high pulse on RTS. A sender uses RTS to hold off its next character. Downstream logic drains the FIFO through a valid/ready port.

If the stop bit is low, the byte is thrown away and a sticky framing flag is set. If the FIFO is full when a frame completes, the byte is thrown away and a sticky overrun flag is set. Both flags clear only on reset.

Top module: `uart_rx_rts`

## Requirements
- R1: A frame with start bit 0, eight data bits sent LSB first, and stop bit 1 puts its data byte into the FIFO. Bytes leave the read port in arrival order.
- R2: A low pulse on the line shorter than half a bit time is ignored. It stores no byte, gives no RTS pulse and sets no flag.
- R3: Each accepted byte raises RTS for exactly XFER_CYCLES consecutive clock cycles, and the byte becomes readable after that step. While the FIFO is not full and no transfer is under way, RTS is 0.
- R4: A frame whose stop bit samples 0 is dropped without an RTS pulse. It sets frame_err_o, which stays 1 until reset.
- R5: RTS is 1 whenever the FIFO holds FIFO_DEPTH bytes. It returns to 0 once a byte is read out.
- R6: A frame that completes while the FIFO is full is dropped, and the FIFO contents stay as they were. It sets overrun_o, which stays 1 until reset.
- R7: rd_valid_o is 1 exactly when the FIFO is not empty. While rd_ready_i is 0, rd_data_o and rd_valid_o hold. A byte is removed on a clock edge where rd_valid_o and rd_ready_i are both 1.
- R8: After reset, rts_o, rd_valid_o, frame_err_o and overrun_o are all 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| rts_o | output | 1 | Busy: 1 during byte transfer or when the FIFO is full |
| rd_data_o | output | 8 | Byte at the head of the FIFO |
| rd_valid_o | output | 1 | FIFO not empty |
| rd_ready_i | input | 1 | Consumer takes the head byte when valid |
| frame_err_o | output | 1 | Sticky: a stop bit was sampled low |
| overrun_o | output | 1 | Sticky: a byte arrived while the FIFO was full |

## Verification
Each fault in the receiver's state shows up at the ports within one character time.
- A wrong oversample phase or bit counter puts a shifted or corrupted byte at the read port.
- A transfer counter of the wrong length shows as an RTS pulse of the wrong width, measured at the end of the stop bit.
- A wrong occupancy count shows up when the FIFO fills: RTS fails to stay high, or a ninth byte lands in the FIFO instead of setting the overrun flag.
- Faults in the start check and the stop check show up in a single frame, as a byte or RTS pulse after a short glitch, or as a byte stored from a frame with a low stop bit.

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
  parameter int CLKS_PER_TICK = 4,
  parameter int FIFO_DEPTH    = 8,
  parameter int XFER_CYCLES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic       rts_o,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  input  logic       rd_ready_i,
  output logic       frame_err_o,
  output logic       overrun_o
);
  localparam int TW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int XW = $clog2(XFER_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_XFER} st_t;

  st_t          state;
  logic         rx_meta, rx_s;
  logic [TW-1:0] tick_cnt;
  logic [3:0]   os_cnt;
  logic [2:0]   bit_idx;
  logic [7:0]   shift;
  logic [XW-1:0] xfer_cnt;
  logic [7:0]   mem [FIFO_DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  wire tick = (tick_cnt == TW'(CLKS_PER_TICK - 1));
  wire full = (count_q == CW'(FIFO_DEPTH));
  wire push = (state == S_XFER) && (xfer_cnt == XW'(XFER_CYCLES - 1));
  wire pop  = rd_valid_o && rd_ready_i;

  assign rts_o      = (state == S_XFER) || full;
  assign rd_valid_o = (count_q != '0);
  assign rd_data_o  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tick_cnt <= '0;
    else if (state == S_IDLE || tick)    tick_cnt <= '0;
    else                                 tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      os_cnt      <= '0;
      bit_idx     <= '0;
      shift       <= '0;
      xfer_cnt    <= '0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          os_cnt <= '0;
          if (!rx_s) state <= S_START;
        end
        S_START: if (tick) begin
          if (os_cnt == 4'd7) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            state   <= rx_s ? S_IDLE : S_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == 4'd15) begin
            shift   <= {rx_s, shift[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) state <= S_STOP;
          end
        end
        S_STOP: if (tick) begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == 4'd15) begin
            if (!rx_s) begin
              frame_err_o <= 1'b1;
              state       <= S_IDLE;
            end else if (full) begin
              overrun_o <= 1'b1;
              state     <= S_IDLE;
            end else begin
              xfer_cnt <= '0;
              state    <= S_XFER;
            end
          end
        end
        S_XFER: begin
          xfer_cnt <= xfer_cnt + 1'b1;
          if (push) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

module uart_rx_rts_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rts_o,
  input logic [7:0]    rd_data_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic          frame_err_o,
  input logic          overrun_o,
  input logic [CW-1:0] count_q,
  input logic          push
);
  assert_full_rts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(FIFO_DEPTH)) |-> rts_o);
  assert_hold_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
  assert_frame_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= CW'(FIFO_DEPTH)));
  assert_push_under_rts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> rts_o);
endmodule

bind uart_rx_rts uart_rx_rts_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_o(rts_o), .rd_data_o(rd_data_o),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .frame_err_o(frame_err_o),
  .overrun_o(overrun_o), .count_q(count_q), .push(push)
);

// File: tb/uart_rx_rts_bench.sv
`timescale 1ns/1ps
module uart_rx_rts_bench;
  localparam int CPT   = 4;
  localparam int DEPTH = 8;
  localparam int XFER  = 2;
  localparam int BIT   = 16 * CPT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic rd_ready = 1'b0;
  logic rts, rd_valid, ferr, ovr;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  int rts_hi = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  uart_rx_rts #(.CLKS_PER_TICK(CPT), .FIFO_DEPTH(DEPTH), .XFER_CYCLES(XFER)) u_uart_rx_rts (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .rts_o(rts), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .frame_err_o(ferr), .overrun_o(ovr)
  );

  always @(negedge clk) if (rts) rts_hi++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    rd_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop);
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pop_byte(input string tag, input logic [7:0] exp);
    check(tag, int'(rd_valid), 1);
    check(tag, int'(rd_data), int'(exp));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // {stop bit, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'h55}, {1'b1, 8'hA3}, {1'b1, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h3C}, {1'b1, 8'h81}
  };

  initial begin
    do_reset();
    check("R8 rts after reset", int'(rts), 0);
    check("R8 valid after reset", int'(rd_valid), 0);
    check("R8 frame_err after reset", int'(ferr), 0);
    check("R8 overrun after reset", int'(ovr), 0);

    for (int v = 0; v < 6; v++) begin
      rts_hi = 0;
      send(VEC[v][7:0], VEC[v][8]);
      check(VEC[v][8] ? "R3 rts pulse width" : "R4 no rts pulse on bad stop",
            rts_hi, VEC[v][8] ? XFER : 0);
      if (!VEC[v][8]) check("R4 frame_err set", int'(ferr), 1);
    end
    check("R4 frame_err sticky", int'(ferr), 1);
    check("R3 rts idle low", int'(rts), 0);
    for (int v = 0; v < 6; v++)
      if (VEC[v][8]) pop_byte("R1 byte order", VEC[v][7:0]);
    check("R7 valid low when empty", int'(rd_valid), 0);

    // R2: short glitch
    do_reset();
    rts_hi = 0;
    rx = 1'b0;
    repeat (3 * CPT) @(negedge clk);
    rx = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R2 glitch no byte", int'(rd_valid), 0);
    check("R2 glitch no rts", rts_hi, 0);
    check("R2 glitch no flag", int'(ferr), 0);

    // R5/R6/R7: fill FIFO
    for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), 1'b1);
    check("R5 rts high when full", int'(rts), 1);
    check("R6 overrun clear before", int'(ovr), 0);
    repeat (20) @(negedge clk);
    check("R7 head held while not ready", int'(rd_data), 8'h10);
    check("R5 rts still high", int'(rts), 1);
    send(8'hEE, 1'b1);
    check("R6 overrun set", int'(ovr), 1);
    pop_byte("R7 pop head", 8'h10);
    check("R5 rts low after read", int'(rts), 0);
    for (int i = 1; i < DEPTH; i++) pop_byte("R6 contents unchanged", 8'h10 + 8'(i));
    check("R6 dropped byte absent", int'(rd_valid), 0);
    check("R6 overrun sticky", int'(ovr), 1);

    do_reset();
    check("R8 flags cleared by reset", int'(ovr) + int'(ferr), 0);
    check("R8 FIFO empty after reset", int'(rd_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule